// File: doc/BRIEF.md
# Banked USB IN Endpoint Transmit Buffer

This block is the transmit side of one USB device IN endpoint. It holds one or two packet banks, each sized for one maximum-length packet. Software fills the bank the block currently offers it, one byte per write, and then gives that bank to hardware by writing a one to the ownership-clear input. Two status flags guide software. The ownership flag means the current bank belongs to software. The transmit-ready flag is a clearable copy of the ownership flag and drives the endpoint interrupt.

On the host side, each IN token gets one registered response on the next cycle. If the oldest released bank is waiting, the block replies with a send, giving that bank's index and byte count. The host-side logic then reads the bytes through a combinational read port. If no bank is waiting, the reply is a NAK. A host acknowledge frees the bank that was sent, and transmission moves on to the other bank. The endpoint enable input stands for "enabled and configured". While it is low, the block clears its bank state and stays silent.

Top module: `usb_in_ep_buf`

## Requirements
- R1: While the endpoint is enabled, txReady and fifoOwn both become 1 on the cycle the current bank becomes free for software. This happens when the endpoint is enabled, when the pointer moves to a free bank, or when the host acknowledges the current bank. The two flags therefore rise together. txReady is never 1 while fifoOwn is 0.
- R2: epIrq is 1 exactly when txReady is 1 and the interrupt enable is 1. A pulse on setIrqEn sets the interrupt enable. A pulse on clrIrqEn clears it. Both take effect one cycle later.
- R3: A pulse on clrTxRdy clears txReady only. fifoOwn, wrAllowed, the stored bytes and the byte count are unchanged.
- R4: A pulse on clrOwn while fifoOwn is 1 releases the current bank to hardware. With two banks, it also moves the current-bank pointer to the other bank (0, then 1, then 0). On the next cycle, txReady and fifoOwn are both 1 if the new current bank is free, and both 0 if it is not.
- R5: wrAllowed is 1 exactly when fifoOwn is 1 and the current bank holds fewer than MAX_PKT bytes. Each accepted write stores wrByte at the next byte offset of the current bank, starting at offset 0.
- R6: An IN token that arrives while enabled, with no bank released to hardware, is answered by respNak high for one cycle, on the cycle after the token. respSend stays low.
- R7: An IN token that arrives while a released bank is waiting is answered, one cycle later, by respSend high for one cycle. respBank gives the oldest released bank and respLen gives its byte count (0 to MAX_PKT; zero-length packets are allowed). rdData returns byte rdAddr of that bank. A token with no acknowledge in between resends the same bank. A hostAck frees the bank and moves transmission to the other bank.
- R8: A write while wrAllowed is 0 is not stored. While enabled, it sets overflowErr, which stays set until the endpoint is disabled.
- R9: While epEnable is 0, IN tokens get neither respSend nor respNak and writes are ignored. Both flags, all byte counts, the released state, both bank pointers and overflowErr are cleared.
- R10: With a single bank (NUM_BANKS = 1), clrOwn makes txReady and fifoOwn 0 until the host acknowledges the bank, and then both return to 1. A clrOwn while fifoOwn is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epEnable | input | 1 | Endpoint enabled and configured |
| setIrqEn | input | 1 | Write-one pulse that sets the interrupt enable |
| clrIrqEn | input | 1 | Write-one pulse that clears the interrupt enable |
| clrTxRdy | input | 1 | Write-one pulse that clears txReady |
| clrOwn | input | 1 | Write-one pulse that clears ownership and releases the current bank |
| wrValid | input | 1 | Byte write strobe from software |
| wrByte | input | 8 | Byte to store |
| inToken | input | 1 | IN token received from the host |
| hostAck | input | 1 | Host acknowledged the packet that was sent |
| rdAddr | input | $clog2(MAX_PKT) | Byte offset to read in the bank being sent |
| txReady | output | 1 | Transmit-ready interrupt flag |
| fifoOwn | output | 1 | Current bank is owned by software |
| wrAllowed | output | 1 | Current bank can take another byte |
| epIrq | output | 1 | Endpoint interrupt |
| overflowErr | output | 1 | Sticky flag for a write that was not allowed |
| respSend | output | 1 | Response to the token: send the packet |
| respNak | output | 1 | Response to the token: NAK |
| respBank | output | 1 | Bank being sent |
| respLen | output | $clog2(MAX_PKT+1) | Byte count of the packet being sent |
| rdData | output | 8 | Byte at rdAddr in the bank being sent |

## Verification
A wrong bank pointer shows up on the very next token, as the wrong respBank or respLen, or as bytes at rdData that were written into the other bank. A wrong released-state bit shows up one cycle after a token, as a NAK where a send was expected or the reverse, and as flags that do not reload after a switch. Count errors show up at once, as wrAllowed dropping at the wrong fill level or as a wrong respLen on the next send. Overflow and disable handling are checked through overflowErr and through the silence of the response outputs.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrSel;
    logic freeEn;
    logic freeSel;
    logic flush;
    logic curSel;
    logic txSel;
  } epStrobe_t;
endpackage

// File: rtl/usb_in_ep_data.sv
module usb_in_ep_data #(
  parameter int NUM_BANKS = 2,
  parameter int MAX_PKT   = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  usb_in_ep_pkg::epStrobe_t stb,
  input  logic [7:0]              wrByte,
  input  logic [AW-1:0]           rdAddr,
  output logic [CW-1:0]           curCount,
  output logic [CW-1:0]           txCount,
  output logic [7:0]              rdData
);
  logic [CW-1:0] count [NUM_BANKS];
  logic [7:0]    mem   [NUM_BANKS][MAX_PKT];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN || stb.flush) begin
        count[b] <= '0;
      end else if (stb.freeEn && stb.freeSel == b[0]) begin
        count[b] <= '0;
      end else if (stb.wrEn && stb.wrSel == b[0]) begin
        count[b] <= count[b] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (stb.wrEn && stb.wrSel == b[0]) begin
        mem[b][count[b][AW-1:0]] <= wrByte;
      end
    end
  end

  assign curCount = count[stb.curSel];
  assign txCount  = count[stb.txSel];
  assign rdData   = mem[stb.txSel][rdAddr];
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter int MAX_PKT   = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     epEnable,
  input  logic                     setIrqEn,
  input  logic                     clrIrqEn,
  input  logic                     clrTxRdy,
  input  logic                     clrOwn,
  input  logic                     wrValid,
  input  logic                     inToken,
  input  logic                     hostAck,
  input  logic [CW-1:0]            curCount,
  input  logic [CW-1:0]            txCount,
  output usb_in_ep_pkg::epStrobe_t stb,
  output logic                     txReady,
  output logic                     fifoOwn,
  output logic                     wrAllowed,
  output logic                     epIrq,
  output logic                     overflowErr,
  output logic                     respSend,
  output logic                     respNak,
  output logic                     respBank,
  output logic [CW-1:0]            respLen
);
  logic                 curBank, txBank, irqEn;
  logic [NUM_BANKS-1:0] released, relNext;
  logic                 curNext, txNext, ownNext, rdyNext;
  logic                 accept, doRelease, doFree;

  function automatic logic nextIdx(input logic idx);
    if (NUM_BANKS == 1) return 1'b0;
    else return ~idx;
  endfunction

  always_comb begin
    wrAllowed = fifoOwn && (curCount < CW'(MAX_PKT));
    accept    = wrValid && wrAllowed;
    doRelease = clrOwn && fifoOwn;
    doFree    = hostAck && epEnable && released[txBank];
    relNext   = released;
    if (doFree)    relNext[txBank]  = 1'b0;
    if (doRelease) relNext[curBank] = 1'b1;
    curNext = doRelease ? nextIdx(curBank) : curBank;
    txNext  = doFree ? nextIdx(txBank) : txBank;
    ownNext = epEnable && !relNext[curNext];
    if (!ownNext)                 rdyNext = 1'b0;
    else if (!fifoOwn || doRelease) rdyNext = 1'b1;
    else if (clrTxRdy)            rdyNext = 1'b0;
    else                          rdyNext = txReady;

    stb.wrEn    = accept;
    stb.wrSel   = curBank;
    stb.freeEn  = doFree;
    stb.freeSel = txBank;
    stb.flush   = !epEnable;
    stb.curSel  = curBank;
    stb.txSel   = txBank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn <= 1'b0;
    end else if (clrIrqEn) begin
      irqEn <= 1'b0;
    end else if (setIrqEn) begin
      irqEn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !epEnable) begin
      curBank     <= 1'b0;
      txBank      <= 1'b0;
      released    <= '0;
      fifoOwn     <= 1'b0;
      txReady     <= 1'b0;
      overflowErr <= 1'b0;
      respSend    <= 1'b0;
      respNak     <= 1'b0;
      respBank    <= 1'b0;
      respLen     <= '0;
    end else begin
      curBank  <= curNext;
      txBank   <= txNext;
      released <= relNext;
      fifoOwn  <= ownNext;
      txReady  <= rdyNext;
      if (wrValid && !wrAllowed) overflowErr <= 1'b1;
      respSend <= inToken && released[txBank];
      respNak  <= inToken && !released[txBank];
      respBank <= txBank;
      respLen  <= txCount;
    end
  end

  assign epIrq = txReady && irqEn;
endmodule

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int NUM_BANKS = 2,
  parameter int MAX_PKT   = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          epEnable,
  input  logic          setIrqEn,
  input  logic          clrIrqEn,
  input  logic          clrTxRdy,
  input  logic          clrOwn,
  input  logic          wrValid,
  input  logic [7:0]    wrByte,
  input  logic          inToken,
  input  logic          hostAck,
  input  logic [AW-1:0] rdAddr,
  output logic          txReady,
  output logic          fifoOwn,
  output logic          wrAllowed,
  output logic          epIrq,
  output logic          overflowErr,
  output logic          respSend,
  output logic          respNak,
  output logic          respBank,
  output logic [CW-1:0] respLen,
  output logic [7:0]    rdData
);
  usb_in_ep_pkg::epStrobe_t stb;
  logic [CW-1:0] curCount, txCount;

  usb_in_ep_ctrl #(.NUM_BANKS(NUM_BANKS), .MAX_PKT(MAX_PKT)) ctrl (
    .clk(clk), .rstN(rstN), .epEnable(epEnable), .setIrqEn(setIrqEn),
    .clrIrqEn(clrIrqEn), .clrTxRdy(clrTxRdy), .clrOwn(clrOwn),
    .wrValid(wrValid), .inToken(inToken), .hostAck(hostAck),
    .curCount(curCount), .txCount(txCount), .stb(stb),
    .txReady(txReady), .fifoOwn(fifoOwn), .wrAllowed(wrAllowed),
    .epIrq(epIrq), .overflowErr(overflowErr), .respSend(respSend),
    .respNak(respNak), .respBank(respBank), .respLen(respLen)
  );

  usb_in_ep_data #(.NUM_BANKS(NUM_BANKS), .MAX_PKT(MAX_PKT)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrByte), .rdAddr(rdAddr),
    .curCount(curCount), .txCount(txCount), .rdData(rdData)
  );
endmodule

// File: rtl/usb_in_ep_buf_chk.sv
module usb_in_ep_buf_chk #(
  parameter int NUM_BANKS = 2,
  parameter int MAX_PKT   = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          epEnable,
  input logic          wrValid,
  input logic          inToken,
  input logic          txReady,
  input logic          fifoOwn,
  input logic          wrAllowed,
  input logic          epIrq,
  input logic          overflowErr,
  input logic          respSend,
  input logic          respNak,
  input logic [CW-1:0] respLen
);
  assert_rdy_needs_own_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> fifoOwn);
  assert_irq_needs_rdy_R2: assert property (@(posedge clk) disable iff (!rstN)
    epIrq |-> txReady);
  assert_wr_needs_own_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrAllowed |-> fifoOwn);
  assert_single_resp_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({respSend, respNak}) <= 1);
  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    respSend |-> (respLen <= CW'(MAX_PKT)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (epEnable && wrValid && !wrAllowed) |=> overflowErr);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && epEnable) |=> overflowErr);
  assert_silent_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!epEnable && inToken) |=> (!respSend && !respNak));
endmodule

bind usb_in_ep_buf usb_in_ep_buf_chk #(.NUM_BANKS(NUM_BANKS), .MAX_PKT(MAX_PKT)) chk (
  .clk(clk), .rstN(rstN), .epEnable(epEnable), .wrValid(wrValid),
  .inToken(inToken), .txReady(txReady), .fifoOwn(fifoOwn),
  .wrAllowed(wrAllowed), .epIrq(epIrq), .overflowErr(overflowErr),
  .respSend(respSend), .respNak(respNak), .respLen(respLen)
);

// File: tb/usb_in_ep_buf_test.sv
`timescale 1ns/1ps
module usb_in_ep_buf_test;
  logic clk = 0, rstN = 0;
  logic epEnable = 0, setIrqEn = 0, clrIrqEn = 0, clrTxRdy = 0, clrOwn = 0;
  logic wrValid = 0, inToken = 0, hostAck = 0;
  logic [7:0] wrByte = 0;
  logic [5:0] rdAddr = 0;
  logic txReady, fifoOwn, wrAllowed, epIrq, overflowErr, respSend, respNak, respBank;
  logic [6:0] respLen;
  logic [7:0] rdData;

  logic enB = 0, clrOwnB = 0, wrValidB = 0, inTokenB = 0, hostAckB = 0;
  logic [7:0] wrByteB = 0;
  logic [5:0] rdAddrB = 0;
  logic txReadyB, fifoOwnB, wrAllowedB, epIrqB, ovfB, respSendB, respNakB, respBankB;
  logic [6:0] respLenB;
  logic [7:0] rdDataB;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  usb_in_ep_buf #(.NUM_BANKS(2), .MAX_PKT(64)) uut (
    .clk(clk), .rstN(rstN), .epEnable(epEnable), .setIrqEn(setIrqEn),
    .clrIrqEn(clrIrqEn), .clrTxRdy(clrTxRdy), .clrOwn(clrOwn),
    .wrValid(wrValid), .wrByte(wrByte), .inToken(inToken), .hostAck(hostAck),
    .rdAddr(rdAddr), .txReady(txReady), .fifoOwn(fifoOwn),
    .wrAllowed(wrAllowed), .epIrq(epIrq), .overflowErr(overflowErr),
    .respSend(respSend), .respNak(respNak), .respBank(respBank),
    .respLen(respLen), .rdData(rdData)
  );

  usb_in_ep_buf #(.NUM_BANKS(1), .MAX_PKT(64)) uutSingle (
    .clk(clk), .rstN(rstN), .epEnable(enB), .setIrqEn(1'b0),
    .clrIrqEn(1'b0), .clrTxRdy(1'b0), .clrOwn(clrOwnB),
    .wrValid(wrValidB), .wrByte(wrByteB), .inToken(inTokenB), .hostAck(hostAckB),
    .rdAddr(rdAddrB), .txReady(txReadyB), .fifoOwn(fifoOwnB),
    .wrAllowed(wrAllowedB), .epIrq(epIrqB), .overflowErr(ovfB),
    .respSend(respSendB), .respNak(respNakB), .respBank(respBankB),
    .respLen(respLenB), .rdData(rdDataB)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeBytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wrValid = 1; wrByte = 8'(base + i);
      step();
    end
    wrValid = 0;
  endtask

  task automatic token();
    inToken = 1; step(); inToken = 0;
  endtask

  task automatic testReset();
    check("R9 reset txReady", txReady, 0);
    check("R9 reset fifoOwn", fifoOwn, 0);
    check("R9 reset wrAllowed", wrAllowed, 0);
    token();
    check("R9 disabled token no send", respSend, 0);
    check("R9 disabled token no nak", respNak, 0);
  endtask

  task automatic testEnableIrq();
    epEnable = 1; step();
    check("R1 txReady on enable", txReady, 1);
    check("R1 fifoOwn on enable", fifoOwn, 1);
    check("R5 wrAllowed empty bank", wrAllowed, 1);
    check("R2 irq off while disabled", epIrq, 0);
    setIrqEn = 1; step(); setIrqEn = 0;
    check("R2 irq after enable", epIrq, 1);
  endtask

  task automatic testNak();
    token();
    check("R6 nak when none released", respNak, 1);
    check("R6 no send when none released", respSend, 0);
    step();
    check("R6 nak one cycle", respNak, 0);
  endtask

  task automatic testFillRelease();
    writeBytes(3, 8'hA0);
    clrTxRdy = 1; step(); clrTxRdy = 0;
    check("R3 txReady cleared", txReady, 0);
    check("R3 fifoOwn kept", fifoOwn, 1);
    check("R3 wrAllowed kept", wrAllowed, 1);
    check("R2 irq follows txReady", epIrq, 0);
    writeBytes(1, 8'hA3);
    clrOwn = 1; step(); clrOwn = 0;
    check("R4 txReady reload free bank1", txReady, 1);
    check("R4 fifoOwn reload free bank1", fifoOwn, 1);
    check("R2 irq again", epIrq, 1);
  endtask

  task automatic testSendBank0();
    token();
    check("R7 send bank0", respSend, 1);
    check("R7 bank index 0", respBank, 0);
    check("R7 len 4 incl. bytes before clrTxRdy (R3)", respLen, 4);
    for (int i = 0; i < 4; i++) begin
      rdAddr = 6'(i); #1;
      check("R7 read byte bank0", rdData, 8'hA0 + i);
    end
    step();
    token();
    check("R7 resend without ack", respSend, 1);
    check("R7 resend same len", respLen, 4);
    hostAck = 1; step(); hostAck = 0;
    token();
    check("R6 nak after ack bank1 not released", respNak, 1);
  endtask

  task automatic testFullOverflow();
    writeBytes(63, 8'h40);
    check("R5 wrAllowed at 63", wrAllowed, 1);
    writeBytes(1, 8'h7F);
    check("R5 wrAllowed low at max", wrAllowed, 0);
    check("R5 fifoOwn still at max", fifoOwn, 1);
    check("R8 no ovf yet", overflowErr, 0);
    writeBytes(1, 8'hEE);
    check("R8 overflow set", overflowErr, 1);
    clrOwn = 1; step(); clrOwn = 0;
    check("R4 pointer back to bank0 free", fifoOwn, 1);
    check("R4 wrAllowed in bank0", wrAllowed, 1);
    token();
    check("R7 send bank1", respSend, 1);
    check("R7 bank index 1", respBank, 1);
    check("R8 len stays max", respLen, 64);
    rdAddr = 0; #1;
    check("R5 first byte bank1", rdData, 8'h40);
    rdAddr = 63; #1;
    check("R8 last byte not overwritten", rdData, 8'h7F);
    check("R8 overflow sticky", overflowErr, 1);
  endtask

  task automatic testBothBusyZeroLen();
    clrOwn = 1; step(); clrOwn = 0;
    check("R4 both busy txReady", txReady, 0);
    check("R4 both busy fifoOwn", fifoOwn, 0);
    check("R5 both busy wrAllowed", wrAllowed, 0);
    hostAck = 1; step(); hostAck = 0;
    check("R1 txReady on free", txReady, 1);
    check("R1 fifoOwn on free", fifoOwn, 1);
    token();
    check("R7 zero length send", respSend, 1);
    check("R7 zero length bank0", respBank, 0);
    check("R7 zero length", respLen, 0);
    hostAck = 1; step(); hostAck = 0;
    clrIrqEn = 1; step(); clrIrqEn = 0;
    check("R2 irq disabled", epIrq, 0);
    check("R2 txReady still set", txReady, 1);
  endtask

  task automatic testDisable();
    epEnable = 0; step();
    check("R9 flags cleared", txReady + fifoOwn, 0);
    check("R9 overflow cleared", overflowErr, 0);
    writeBytes(1, 8'h11);
    check("R9 write ignored no ovf", overflowErr, 0);
    token();
    check("R9 no response disabled", respSend + respNak, 0);
    epEnable = 1; step();
    token();
    check("R9 nak after re-enable state cleared", respNak, 1);
  endtask

  task automatic testSingleBank();
    enB = 1; step();
    check("R10 single flags on enable", txReadyB + fifoOwnB, 2);
    wrValidB = 1; wrByteB = 8'h55; step();
    wrByteB = 8'h66; step(); wrValidB = 0;
    clrOwnB = 1; step(); clrOwnB = 0;
    check("R10 txReady low after release", txReadyB, 0);
    check("R10 fifoOwn low after release", fifoOwnB, 0);
    clrOwnB = 1; step(); clrOwnB = 0;
    inTokenB = 1; step(); inTokenB = 0;
    check("R10 send len 2", respLenB, 2);
    check("R10 send", respSendB, 1);
    rdAddrB = 1; #1;
    check("R10 byte 1", rdDataB, 8'h66);
    hostAckB = 1; step(); hostAckB = 0;
    check("R10 flags back after ack", txReadyB + fifoOwnB, 2);
    inTokenB = 1; step(); inTokenB = 0;
    check("R10 extra clrOwn ignored: nak", respNakB, 1);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1; step();
    testReset();
    testEnableIrq();
    testNak();
    testFillRelease();
    testSendBank0();
    testFullOverflow();
    testBothBusyZeroLen();
    testDisable();
    testSingleBank();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule